// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for each cycle of a four-beat burst access. A load cycle captures a complete external address and starts a burst at that word. Each following advance cycle moves the two low address bits to the next position inside the same aligned four-word group. The upper bits of the address never change during a burst.

A static mode input selects one of two step orders. In wrap-around linear order, beat n uses low bits (start + n) mod 4. In interleaved order, beat n uses start XOR n. A clock enable freezes the sequencer completely.

A load cycle that arrives while the chip-select result is false ends any burst in progress. The valid flag then stays low until the next selected load.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, acc_valid is 0 and acc_addr is all zeros.
- R2: A cycle with clk_en=1, adv_ld=0 and sel=1 sets acc_valid=1 and acc_addr=ext_addr from the next cycle on.
- R3: With mode_ilv=0, the n-th advance after a load gives acc_addr[1:0] = (start + n) mod 4, where start is ext_addr[1:0] at the load.
- R4: With mode_ilv=1, the n-th advance after a load gives acc_addr[1:0] = start XOR n.
- R5: During advance cycles (adv_ld=1), acc_addr[ADDR_W-1:2] keeps the value it had at the load, and ext_addr and sel have no effect.
- R6: Advancing past the fourth beat wraps within the group, so beat n and beat n+4 have the same address.
- R7: A cycle with clk_en=1, adv_ld=0 and sel=0 clears acc_valid on the next cycle, and acc_addr keeps its last value.
- R8: While clk_en=0, acc_addr and acc_valid do not change, whatever the other inputs do.
- R9: Advance cycles while acc_valid=0 leave acc_valid at 0 and acc_addr unchanged.
- R10: A selected load during a burst restarts the sequence at beat 0 of the newly presented address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | 1 lets the sequencer update on the edge, 0 freezes it |
| sel | input | 1 | Chip-select result, 1 = selected, sampled on load cycles |
| adv_ld | input | 1 | 0 = load cycle, 1 = advance cycle |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| ext_addr | input | ADDR_W | External word address, captured on a selected load |
| acc_addr | output | ADDR_W | Address of the current burst beat |
| acc_valid | output | 1 | 1 while a burst is active |

## Verification
Every state change lands exactly one clock edge after the controlling inputs are sampled. Because acc_addr follows mode_ilv combinationally, a change of mode is visible in the same cycle. The bench drives inputs on the falling edge and lets the model and the design both take the rising edge. It then compares acc_addr and acc_valid on the next falling edge, one edge after the stimulus. Stretches with clk_en low are compared on every cycle, which shows that nothing has moved.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sel,
  input  logic              adv_ld,
  input  logic              mode_ilv,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_valid
);

  localparam int GRP_W = ADDR_W - 2;

  logic [GRP_W-1:0] grp_q;
  logic [1:0]       start_q;
  logic [1:0]       beat_q;
  logic             valid_q;

  wire do_load = clk_en & ~adv_ld;
  wire do_step = clk_en & adv_ld & valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q   <= '0;
      start_q <= '0;
      beat_q  <= '0;
      valid_q <= 1'b0;
    end else if (do_load) begin
      valid_q <= sel;
      if (sel) begin
        grp_q   <= ext_addr[ADDR_W-1:2];
        start_q <= ext_addr[1:0];
        beat_q  <= 2'd0;
      end
    end else if (do_step) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  wire [1:0] lin_low = start_q + beat_q;
  wire [1:0] ilv_low = start_q ^ beat_q;

  assign acc_addr  = {grp_q, mode_ilv ? ilv_low : lin_low};
  assign acc_valid = valid_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(acc_addr) && $stable(acc_valid));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !adv_ld && sel |=> acc_valid && acc_addr == $past(ext_addr));

  assert_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !adv_ld && !sel |=> !acc_valid);

  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv_ld && acc_valid |=>
      acc_valid && acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2]));

  assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv_ld && !acc_valid |=> !acc_valid && $stable(acc_addr));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv_ld && acc_valid && !mode_ilv && $stable(mode_ilv) |=>
      (mode_ilv || acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1));

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b0;
  logic          sel = 1'b0;
  logic          adv_ld = 1'b0;
  logic          mode_ilv = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] acc_addr;
  logic          acc_valid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel(sel), .adv_ld(adv_ld),
    .mode_ilv(mode_ilv), .ext_addr(ext_addr), .acc_addr(acc_addr), .acc_valid(acc_valid)
  );

  bit            m_valid = 0;
  logic [AW-1:0] m_base = '0;
  int            m_start = 0;
  int            m_n = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_base = '0; m_start = 0; m_n = 0;
    end else if (clk_en) begin
      if (!adv_ld) begin
        m_valid = sel;
        if (sel) begin
          m_base = ext_addr; m_start = int'(ext_addr[1:0]); m_n = 0;
        end
      end else if (m_valid) begin
        m_n++;
      end
    end
  end

  function automatic logic [AW-1:0] model_addr();
    int low;
    low = mode_ilv ? (m_start ^ (m_n % 4)) : ((m_start + m_n) % 4);
    return {m_base[AW-1:2], 2'(low)};
  endfunction

  task automatic compare();
    logic [AW-1:0] ea;
    ea = model_addr();
    compared++;
    if (acc_addr !== ea || acc_valid !== m_valid) begin
      mismatched++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
               cur_req, acc_addr, acc_valid, ea, m_valid);
    end
  endtask

  task automatic cyc(input logic en, input logic s, input logic adv, input logic [AW-1:0] a);
    clk_en = en; sel = s; adv_ld = adv; ext_addr = a;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic burst(input logic [AW-1:0] a, input int steps);
    cyc(1, 1, 0, a);
    for (int i = 0; i < steps; i++) cyc(1, ~sel, 1, a ^ 20'h5A5A5);
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R1";
    compare();
    cyc(1, 1, 0, 20'hABCDE);
    cyc(0, 1, 0, 20'h12345);
    rst_n = 1'b1;
    cyc(1, 0, 1, 20'h0);

    cur_req = "R2";
    cyc(1, 1, 0, 20'h3C3C1);
    cyc(1, 1, 0, 20'hFFFFF);

    cur_req = "R3";
    mode_ilv = 1'b0;
    for (int s = 0; s < 4; s++) burst(20'h81230 + 20'(s), 3);

    cur_req = "R4";
    mode_ilv = 1'b1;
    for (int s = 0; s < 4; s++) burst(20'h4F5E0 + 20'(s), 3);

    cur_req = "R5";
    burst(20'h12346, 2);

    cur_req = "R6";
    mode_ilv = 1'b0;
    burst(20'h77773, 9);
    mode_ilv = 1'b1;
    burst(20'h00002, 9);

    cur_req = "R8";
    cyc(1, 1, 0, 20'hBEEF1);
    cyc(1, 1, 1, 20'h0);
    for (int i = 0; i < 4; i++) cyc(0, i[0], i[1], 20'hCAFE0 + 20'(i));
    cyc(1, 1, 1, 20'h0);

    cur_req = "R7";
    cyc(1, 0, 0, 20'h11111);
    cyc(1, 1, 1, 20'h22222);

    cur_req = "R9";
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 20'h33333);
    cyc(0, 1, 0, 20'h44444);

    cur_req = "R10";
    mode_ilv = 1'b0;
    cyc(1, 1, 0, 20'h55551);
    cyc(1, 1, 1, 20'h0);
    cyc(1, 1, 0, 20'h66663);
    cyc(1, 1, 1, 20'h0);
    mode_ilv = 1'b1;
    cyc(1, 1, 0, 20'h99992);
    cyc(1, 1, 1, 20'h0);
    cyc(1, 1, 1, 20'h0);

    cur_req = "R7";
    cyc(1, 0, 0, 20'h0);
    cyc(1, 0, 1, 20'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule